// File: doc/BRIEF.md
# USB Bus Reset Detector

This block watches the sampled levels of the two USB data lines and recognises a bus reset. A bus reset is a single-ended zero: both lines low at the same time. The condition counts as a reset only after it has lasted for a programmed time inside the 12 to 16 µs window. A free-running reference clock of known frequency measures how long the condition lasts. Both line levels pass through a synchroniser. A saturating counter then measures the length of the current single-ended-zero run. It starts again from zero whenever either line is seen high.

When a run reaches the threshold, the block raises a one-cycle interrupt request for the interrupt controller. In this request set, the bus-reset source has the highest priority of the maskable sources. In the same cycle the block sets a sticky status flag, which is meant to sit at bit 5 of the processor status and control register. Firmware clears the flag by writing a 1 to it. A single long run gives exactly one request. The detector arms again only after the lines have left the single-ended-zero state.

The threshold is a parameter counted in reference-clock cycles. By default it is derived from the clock frequency so that it equals 14 µs, rounded up to a whole cycle.

Top module: `usb_se0_reset_det`

## Requirements
- R1: A single-ended zero is `dp_i` = 0 and `dm_i` = 0 together. The states (dp,dm) = (1,0), (0,1) and (1,1) never lead to a detection, however long they last.
- R2: A detection happens only after THRESH_CYC consecutive synchronised clock cycles of single-ended zero. A run of THRESH_CYC-1 cycles or fewer produces no request and leaves the flag unchanged.
- R3: Suppose both lines are first sampled low at edge 1 and stay low. Then `irq_o` is high in exactly the cycle after edge THRESH_CYC+2, a latency made of two synchroniser stages, the counter and the output register.
- R4: `irq_o` is a single-cycle pulse. However long a run lasts, it produces at most one pulse. After the lines leave single-ended zero for at least one cycle, a new run of THRESH_CYC cycles produces a new pulse.
- R5: `stat_o` rises in the same cycle as `irq_o`. It then stays at 1 until firmware clears it.
- R6: A write is a cycle with `clr_wr_i` = 1. It clears `stat_o` at the next edge if `clr_data_i` = 1. With `clr_data_i` = 0 it has no effect.
- R7: If a clearing write and a detection fall on the same edge, the detection wins: `stat_o` is 1 afterwards and `irq_o` still pulses.
- R8: While `rst_ni` is low, `stat_o` and `irq_o` are 0 and the synchroniser holds the idle state (1,0). Reset release is synchronised by two flops, so lines that are low through reset give a pulse in the cycle after edge THRESH_CYC+4, counted from the release.
- R9: A single cycle in which either line is high, in the middle of a run, restarts the duration count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dp_i | input | 1 | Sampled D+ line level, asynchronous |
| dm_i | input | 1 | Sampled D- line level, asynchronous |
| clr_wr_i | input | 1 | Firmware write strobe to the status flag |
| clr_data_i | input | 1 | Written bit value; 1 clears the flag |
| stat_o | output | 1 | Sticky bus-reset status flag |
| irq_o | output | 1 | One-cycle bus-reset interrupt request |

## Verification
A firmware clear of the status flag and a fresh detection can fall on the same clock edge. The bench provokes this by starting a run long enough to qualify, then issuing a one-cycle clearing write. The write is swept over every edge from several cycles before the detection edge to several cycles after it. The arithmetic expectation is that the flag survives any write that lands on or before the detection edge and is cleared by any write that lands after it. A write carrying a 0 on the detection edge is also tried, and the interrupt pulse is checked to appear exactly once in every case.

// File: rtl/usb_rstdet_pkg.sv
package usb_rstdet_pkg;

  // Pair of line levels carried through the synchroniser.
  typedef struct packed {
    logic dp;
    logic dm;
  } usb_lines_t;

  // Idle full-speed state used as synchroniser reset value (not SE0).
  localparam usb_lines_t LINES_IDLE = '{dp: 1'b1, dm: 1'b0};

  // Threshold in reference cycles, rounded up: ceil(khz * ns / 1e6).
  function automatic int unsigned calc_thresh(input int unsigned clk_khz,
                                              input int unsigned dur_ns);
    longint unsigned prod;
    prod = longint'(clk_khz) * longint'(dur_ns);
    return int'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

endpackage

// File: rtl/usb_rstdet_rst_sync.sv
module usb_rstdet_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/usb_rstdet_sync.sv
module usb_rstdet_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/usb_rstdet_timer.sv
module usb_rstdet_timer #(
  parameter int unsigned THRESH_CYC = 672,
  localparam int unsigned CW = $clog2(THRESH_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic se0_i,
  output logic hit_o
);
  localparam logic [CW-1:0] LAST = CW'(THRESH_CYC - 1);
  localparam logic [CW-1:0] SAT  = CW'(THRESH_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // Count while SE0 lasts, saturate at the threshold (disarmed state),
  // return to zero as soon as either line is high (re-armed).
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!se0_i) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (cnt_q != SAT) begin
      cnt_d  = cnt_q + CW'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit_o = se0_i && (cnt_q == LAST);
endmodule

// File: rtl/usb_rstdet_flag.sv
module usb_rstdet_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_wr_i,
  input  logic clr_data_i,
  output logic stat_o,
  output logic irq_o
);
  logic stat_q, stat_d;
  logic irq_q, irq_d;
  logic clr_req;

  always_comb begin
    clr_req = clr_wr_i && clr_data_i;
    irq_d   = hit_i;
    // Detection takes precedence over a same-cycle clear.
    if (hit_i)        stat_d = 1'b1;
    else if (clr_req) stat_d = 1'b0;
    else              stat_d = stat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/usb_se0_reset_det.sv
module usb_se0_reset_det
  import usb_rstdet_pkg::*;
#(
  parameter int unsigned REF_CLK_KHZ = 48_000,
  parameter int unsigned RESET_NS    = 14_000,
  parameter int unsigned THRESH_CYC  = calc_thresh(REF_CLK_KHZ, RESET_NS),
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dp_i,
  input  logic dm_i,
  input  logic clr_wr_i,
  input  logic clr_data_i,
  output logic stat_o,
  output logic irq_o
);
  localparam int unsigned LW = $bits(usb_lines_t);

  logic       rst_n_s;
  usb_lines_t lines_raw;
  usb_lines_t lines_s;
  logic       dp_s, dm_s;
  logic       se0;
  logic       hit;

  usb_rstdet_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  assign lines_raw = '{dp: dp_i, dm: dm_i};

  usb_rstdet_sync #(
    .WIDTH   (LW),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (LINES_IDLE)
  ) u_line_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .d_i    (lines_raw),
    .q_o    (lines_s)
  );

  assign dp_s = lines_s.dp;
  assign dm_s = lines_s.dm;
  assign se0  = !dp_s && !dm_s;

  usb_rstdet_timer #(.THRESH_CYC(THRESH_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .se0_i  (se0),
    .hit_o  (hit)
  );

  usb_rstdet_flag u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .hit_i      (hit),
    .clr_wr_i   (clr_wr_i),
    .clr_data_i (clr_data_i),
    .stat_o     (stat_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/usb_se0_reset_det_chk.sv
module usb_se0_reset_det_chk #(
  parameter int unsigned THRESH_CYC = 672
) (
  input logic clk_i,
  input logic rst_n,
  input logic dp_s,
  input logic dm_s,
  input logic hit_i,
  input logic clr_wr_i,
  input logic clr_data_i,
  input logic stat_i,
  input logic irq_i
);
  // Independent run-length counter of synchronised SE0 cycles.
  int unsigned run_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)              run_q <= 0;
    else if (dp_s || dm_s)   run_q <= 0;
    else if (run_q < 32'hFFFF_0000) run_q <= run_q + 1;
  end

  assert_irq_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_i |=> !irq_i);

  assert_irq_needs_se0_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_i |-> $past(!dp_s && !dm_s));

  assert_hit_run_length_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    hit_i |-> (run_q == THRESH_CYC - 1));

  assert_irq_sets_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_i |-> stat_i);

  assert_flag_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (stat_i && !(clr_wr_i && clr_data_i)) |=> stat_i);

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (clr_wr_i && clr_data_i && !hit_i) |=> !stat_i);

  assert_detect_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    hit_i |=> (stat_i && irq_i));
endmodule

bind usb_se0_reset_det usb_se0_reset_det_chk #(.THRESH_CYC(THRESH_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n_s),
  .dp_s       (dp_s),
  .dm_s       (dm_s),
  .hit_i      (hit),
  .clr_wr_i   (clr_wr_i),
  .clr_data_i (clr_data_i),
  .stat_i     (stat_o),
  .irq_i      (irq_o)
);

// File: tb/usb_se0_reset_det_test.sv
module usb_se0_reset_det_test;
  localparam int T = 6;

  logic clk = 1'b0;
  logic rst_ni;
  logic dp, dm, clr_wr, clr_data;
  logic stat, irq;

  int n_cmp = 0;
  int n_bad = 0;
  int wd    = 0;

  always #4 clk = ~clk;

  usb_se0_reset_det #(.THRESH_CYC(T)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .dp_i       (dp),
    .dm_i       (dm),
    .clr_wr_i   (clr_wr),
    .clr_data_i (clr_data),
    .stat_o     (stat),
    .irq_o      (irq)
  );

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_and_clear();
    dp = 1'b1; dm = 1'b0;
    repeat (4) @(negedge clk);
    clr_wr = 1'b1; clr_data = 1'b1;
    @(negedge clk);
    clr_wr = 1'b0; clr_data = 1'b0;
    @(negedge clk);
    chk(stat == 1'b0, "R6 clear before run", stat, 0);
  endtask

  // Line value driven for edge index i; gk selects the non-SE0 gap state.
  task automatic set_lines(input int i, input int lo1, input int gap,
                           input int gk, input int lo2);
    if (i <= lo1)                 begin dp = 1'b0; dm = 1'b0; end
    else if (i <= lo1 + gap) begin
      case (gk)
        0:       begin dp = 1'b1; dm = 1'b0; end
        1:       begin dp = 1'b0; dm = 1'b1; end
        default: begin dp = 1'b1; dm = 1'b1; end
      endcase
    end
    else if (i <= lo1 + gap + lo2) begin dp = 1'b0; dm = 1'b0; end
    else                          begin dp = 1'b1; dm = 1'b0; end
  endtask

  task automatic run_seq(input int lo1, input int gap, input int gk, input int lo2);
    int win, n, p1, p2, en, e1, e2;
    idle_and_clear();
    win = lo1 + gap + lo2 + T + 8;
    n = 0; p1 = -1; p2 = -1;
    set_lines(1, lo1, gap, gk, lo2);
    for (int i = 1; i <= win; i++) begin
      @(negedge clk);
      if (irq) begin
        n++;
        if (n == 1) p1 = i; else p2 = i;
      end
      set_lines(i + 1, lo1, gap, gk, lo2);
    end
    // Expected pulses computed from run lengths (R2, R3, R4, R9).
    en = 0; e1 = -1; e2 = -1;
    if (gap == 0) begin
      if (lo1 + lo2 >= T) begin en = 1; e1 = T + 2; end
    end else begin
      if (lo1 >= T) begin en++; e1 = T + 2; end
      if (lo2 >= T) begin
        en++;
        if (en == 1) e1 = lo1 + gap + T + 2; else e2 = lo1 + gap + T + 2;
      end
    end
    chk(n == en, "R2/R4/R9 pulse count", n, en);
    chk(p1 == e1, "R3 first pulse cycle", p1, e1);
    chk(p2 == e2, "R4 second pulse cycle", p2, e2);
    chk(stat == (en > 0), "R5 sticky flag after run", stat, int'(en > 0));
  endtask

  // One-line-low or both-high states held long: no detection (R1).
  task automatic run_nonse0(input logic vp, input logic vm);
    int n;
    idle_and_clear();
    n = 0;
    dp = vp; dm = vm;
    for (int i = 1; i <= 4 * T; i++) begin
      @(negedge clk);
      if (irq) n++;
    end
    dp = 1'b1; dm = 1'b0;
    chk(n == 0, "R1 non-SE0 state pulses", n, 0);
    chk(stat == 1'b0, "R1 non-SE0 state flag", stat, 0);
  endtask

  // Clearing write sampled at edge k+1 against detection at edge T+2.
  task automatic run_clear(input int k, input logic data);
    int n, exp_s;
    idle_and_clear();
    n = 0;
    dp = 1'b0; dm = 1'b0;
    for (int i = 1; i <= T + 8; i++) begin
      @(negedge clk);
      if (irq) n++;
      if (i == T + 3) begin dp = 1'b1; dm = 1'b0; end
      if (i == k) begin clr_wr = 1'b1; clr_data = data; end
      else        begin clr_wr = 1'b0; clr_data = 1'b0; end
    end
    clr_wr = 1'b0; clr_data = 1'b0;
    if (!data)               exp_s = 1;
    else if (k + 1 <= T + 2) exp_s = 1;
    else                     exp_s = 0;
    chk(n == 1, "R7 pulse with clear nearby", n, 1);
    chk(stat == exp_s[0], (k + 1 == T + 2) ? "R7 detect wins" : "R6 clear timing",
        stat, exp_s);
  endtask

  initial begin
    int n, p;
    dp = 1'b1; dm = 1'b0; clr_wr = 1'b0; clr_data = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(stat == 1'b0, "R8 reset flag", stat, 0);
    chk(irq == 1'b0, "R8 reset irq", irq, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(stat == 1'b0 && irq == 1'b0, "R8 after release", {stat, irq}, 0);

    // R1 non-SE0 states
    run_nonse0(1'b1, 1'b0);
    run_nonse0(1'b0, 1'b1);
    run_nonse0(1'b1, 1'b1);

    // R2 R3 R4 R9 sweep over run lengths, gaps and gap states
    for (int lo1 = 0; lo1 <= T + 3; lo1++)
      for (int gap = 0; gap <= 2; gap++)
        for (int gk = 0; gk <= 2; gk++)
          for (int s = 0; s <= 3; s++)
            run_seq(lo1, gap, gk, (s == 0) ? 0 : (s == 1) ? T - 1 : (s == 2) ? T : 3 * T);

    // R6 R7 clear sweep around the detection edge
    for (int k = T - 3; k <= T + 5; k++) run_clear(k, 1'b1);
    run_clear(T + 3, 1'b0);  // R6 write of 0 after detection: no effect
    run_clear(T + 1, 1'b0);

    // R8 lines low through reset
    dp = 1'b0; dm = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(stat == 1'b0 && irq == 1'b0, "R8 reset during SE0", {stat, irq}, 0);
    rst_ni = 1'b1;
    n = 0; p = -1;
    for (int i = 1; i <= T + 10; i++) begin
      @(negedge clk);
      if (irq) begin n++; if (p < 0) p = i; end
    end
    chk(n == 1, "R8 pulses after release", n, 1);
    chk(p == T + 4, "R8 pulse cycle after release", p, T + 4);
    dp = 1'b1; dm = 1'b0;
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule